// File: doc/BRIEF.md
# Deterministic Instruction Line Prefetcher

This block sits between a processor's instruction fetch port and a slow main memory that answers one line per burst. A line is four instructions. The block keeps two one-line buffers. One is the current line, which the processor executes from. The other receives the next sequential line in the background, so straight code is not starved after each line. When the current line holds a branch, no next-line burst is started, and the other buffer keeps whatever it holds. The fetch time of every instruction therefore follows from the code alone, with no cache history.

The processor holds a word address and a request until ready is returned. A hit in either buffer is served in the same cycle. Serving from the background buffer swaps the roles of the two buffers; no data is copied. A miss raises a burst for the missing line once the port is free. Only one burst is ever open. A miss that arrives while a background burst is running waits for that burst and then issues its own.

Top module: `line_prefetcher`

## Requirements
- R1: The fetch address is a word address. The line number is the address shifted right by two, and the word at line offset k is carried in bits [32k+31:32k] of `mem_rdata_i`. The delivered instruction is the word at the requested address.
- R2: After reset both buffers are empty, `fetch_ready_o` is low and `mem_req_o` stays low until the first fetch request.
- R3: A request that misses both buffers while no burst is open raises `mem_req_o` in that same cycle, with `mem_line_o` set to the requested line. `fetch_ready_o` rises in the cycle after `mem_rvalid_i`. With a 38-cycle memory the wait is 38 cycles.
- R4: A request whose line is in either buffer gets `fetch_ready_o` in the cycle it is presented.
- R5: When the current line is valid and branch-free, no burst is open and the other buffer does not already hold the next line, a burst for the current line plus one is raised in that cycle.
- R6: An instruction whose bits [31:26] equal 6'b000100 is a branch. A line containing one starts no next-line burst, so the first fetch past it pays the full miss wait.
- R7: Serving a request from the background buffer makes that buffer current from the next cycle. The next-line burst for it is raised in that cycle.
- R8: At most one burst is open. A miss during an open burst waits for that burst's `mem_rvalid_i` before raising its own request. When the open burst carries the requested line, that data serves the miss.
- R9: Raising a burst invalidates the buffer it will fill. Completing a miss burst invalidates the previously current buffer.
- R10: `fetch_ready_o` is never high while `fetch_req_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Processor fetch request, held until ready |
| fetch_addr_i | input | ADDR_W | Word address of the requested instruction |
| fetch_ready_o | output | 1 | Instruction valid this cycle; transfer on request and ready |
| fetch_instr_o | output | INSTR_W | Requested instruction, zero when not ready |
| mem_req_o | output | 1 | One-cycle burst request to main memory |
| mem_line_o | output | ADDR_W-2 | Line number of the burst |
| mem_rvalid_i | input | 1 | Burst data valid, one cycle |
| mem_rdata_i | input | 4*INSTR_W | Whole line returned by the burst |

## Verification
The bench memory returns a line 38 cycles after the request cycle. A miss therefore completes 38 cycles after the request cycle, and a hit completes in the request cycle itself. A fetch that waits on a background burst completes once that burst has landed: 30 cycles after its request for the second line of a run, 31 cycles in steady state, 34 cycles after a jump into the line in flight, and 72 or 75 cycles when a foreign burst must drain first. The processor model issues each fetch two cycles after the previous delivery and samples at the falling edge. Each vector checks both the exact wait and the instruction word.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int unsigned LP_ADDR_W     = 16;
  localparam int unsigned LP_INSTR_W    = 32;
  localparam int unsigned LP_LINE_WORDS = 4;
  localparam int unsigned LP_OPC_LSB    = 26;
  localparam int unsigned LP_OPC_W      = 6;
  localparam logic [LP_OPC_W-1:0] LP_BR_OPC = 6'b000100;
endpackage

// File: rtl/lp_line_buf.sv
module lp_line_buf #(
  parameter int unsigned INSTR_W    = 32,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned TAG_W      = 14,
  parameter int unsigned OPC_LSB    = 26,
  parameter int unsigned OPC_W      = 6,
  parameter logic [OPC_W-1:0] BR_OPC = 6'b000100,
  localparam int unsigned LINE_W    = INSTR_W * LINE_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_i,
  input  logic              inval_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [LINE_W-1:0] fill_data_i,
  output logic              valid_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [LINE_W-1:0] data_o,
  output logic              br_o
);
  logic [LINE_WORDS-1:0] word_is_br;

  // branch decode on the way in, one result per word
  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_dec
    assign word_is_br[k] = (fill_data_i[k*INSTR_W+OPC_LSB +: OPC_W] == BR_OPC);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      data_o  <= '0;
      br_o    <= 1'b0;
    end else if (fill_i) begin
      valid_o <= 1'b1;
      tag_o   <= fill_tag_i;
      data_o  <= fill_data_i;
      br_o    <= |word_is_br;
    end else if (inval_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lp_fetch_ctrl.sv
module lp_fetch_ctrl #(
  parameter int unsigned TAG_W = 14
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic [TAG_W-1:0]      req_tag_i,
  input  logic [1:0]            buf_valid_i,
  input  logic [1:0][TAG_W-1:0] buf_tag_i,
  input  logic [1:0]            buf_br_i,
  input  logic                  mem_rvalid_i,
  output logic                  sel_o,
  output logic                  hit_o,
  output logic                  hit_buf_o,
  output logic                  mem_req_o,
  output logic [TAG_W-1:0]      mem_line_o,
  output logic [1:0]            fill_o,
  output logic [1:0]            inval_o,
  output logic [TAG_W-1:0]      fill_tag_o
);
  logic             sel_q, busy_q, dem_q;
  logic [TAG_W-1:0] busy_tag_q;
  logic             cur, oth;
  logic             hit_cur, hit_oth, swap, miss;
  logic             issue_dem, issue_pf, fill, flip;
  logic [TAG_W-1:0] next_tag;
  logic             oth_has_next;

  assign cur = sel_q;
  assign oth = ~sel_q;

  assign hit_cur      = buf_valid_i[cur] && (buf_tag_i[cur] == req_tag_i);
  assign hit_oth      = buf_valid_i[oth] && (buf_tag_i[oth] == req_tag_i);
  assign swap         = req_i && !hit_cur && hit_oth;
  assign miss         = req_i && !hit_cur && !hit_oth;
  assign next_tag     = buf_tag_i[cur] + 1'b1;
  assign oth_has_next = buf_valid_i[oth] && (buf_tag_i[oth] == next_tag);

  // demand first; background burst only from a branch-free current line
  assign issue_dem = miss && !busy_q;
  assign issue_pf  = !busy_q && !miss && !swap && buf_valid_i[cur] &&
                     !buf_br_i[cur] && !oth_has_next;
  assign fill      = busy_q && mem_rvalid_i;
  assign flip      = (fill && dem_q) || swap;

  assign mem_req_o  = issue_dem || issue_pf;
  assign mem_line_o = issue_dem ? req_tag_i : next_tag;
  assign fill_tag_o = busy_tag_q;
  assign sel_o      = sel_q;
  assign hit_o      = req_i && (hit_cur || hit_oth);
  assign hit_buf_o  = hit_cur ? cur : oth;

  always_comb begin
    fill_o  = '0;
    inval_o = '0;
    fill_o[oth] = fill;
    if (mem_req_o)    inval_o[oth] = 1'b1;
    if (fill && dem_q) inval_o[cur] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= 1'b0;
      busy_q     <= 1'b0;
      dem_q      <= 1'b0;
      busy_tag_q <= '0;
    end else begin
      if (flip) sel_q <= ~sel_q;
      if (fill) begin
        busy_q <= 1'b0;
      end else if (mem_req_o) begin
        busy_q     <= 1'b1;
        dem_q      <= issue_dem;
        busy_tag_q <= mem_line_o;
      end
    end
  end
endmodule

// File: rtl/line_prefetcher.sv
module line_prefetcher
  import lp_pkg::*;
#(
  parameter int unsigned ADDR_W     = LP_ADDR_W,
  parameter int unsigned INSTR_W    = LP_INSTR_W,
  parameter int unsigned LINE_WORDS = LP_LINE_WORDS,
  parameter int unsigned OPC_LSB    = LP_OPC_LSB,
  parameter int unsigned OPC_W      = LP_OPC_W,
  parameter logic [OPC_W-1:0] BR_OPC = LP_BR_OPC,
  localparam int unsigned OFF_W     = $clog2(LINE_WORDS),
  localparam int unsigned TAG_W     = ADDR_W - OFF_W,
  localparam int unsigned LINE_W    = INSTR_W * LINE_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fetch_ready_o,
  output logic [INSTR_W-1:0] fetch_instr_o,
  output logic              mem_req_o,
  output logic [TAG_W-1:0]  mem_line_o,
  input  logic              mem_rvalid_i,
  input  logic [LINE_W-1:0] mem_rdata_i
);
  logic [TAG_W-1:0]            req_tag;
  logic [OFF_W-1:0]            req_off;
  logic [1:0]                  buf_valid, buf_br, buf_fill, buf_inval;
  logic [1:0][TAG_W-1:0]       buf_tag;
  logic [1:0][LINE_W-1:0]      buf_data;
  logic [TAG_W-1:0]            fill_tag;
  logic                        sel, hit, hit_buf;
  logic [TAG_W-1:0]            cur_tag;
  logic                        cur_br;

  assign req_tag = fetch_addr_i[ADDR_W-1:OFF_W];
  assign req_off = fetch_addr_i[OFF_W-1:0];

  for (genvar b = 0; b < 2; b++) begin : g_buf
    lp_line_buf #(
      .INSTR_W(INSTR_W), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W),
      .OPC_LSB(OPC_LSB), .OPC_W(OPC_W), .BR_OPC(BR_OPC)
    ) u_buf (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fill_i      (buf_fill[b]),
      .inval_i     (buf_inval[b]),
      .fill_tag_i  (fill_tag),
      .fill_data_i (mem_rdata_i),
      .valid_o     (buf_valid[b]),
      .tag_o       (buf_tag[b]),
      .data_o      (buf_data[b]),
      .br_o        (buf_br[b])
    );
  end

  lp_fetch_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (fetch_req_i),
    .req_tag_i    (req_tag),
    .buf_valid_i  (buf_valid),
    .buf_tag_i    (buf_tag),
    .buf_br_i     (buf_br),
    .mem_rvalid_i (mem_rvalid_i),
    .sel_o        (sel),
    .hit_o        (hit),
    .hit_buf_o    (hit_buf),
    .mem_req_o    (mem_req_o),
    .mem_line_o   (mem_line_o),
    .fill_o       (buf_fill),
    .inval_o      (buf_inval),
    .fill_tag_o   (fill_tag)
  );

  assign cur_tag       = buf_tag[sel];
  assign cur_br        = buf_br[sel];
  assign fetch_ready_o = hit;
  assign fetch_instr_o = hit ? buf_data[hit_buf][req_off*INSTR_W +: INSTR_W] : '0;
endmodule

// File: rtl/lp_prefetch_chk.sv
module lp_prefetch_chk #(
  parameter int unsigned TAG_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fetch_req_i,
  input logic [TAG_W-1:0] req_tag_i,
  input logic             fetch_ready_o,
  input logic             mem_req_o,
  input logic [TAG_W-1:0] mem_line_o,
  input logic             mem_rvalid_i,
  input logic [TAG_W-1:0] cur_tag_i,
  input logic             cur_br_i
);
  logic in_flight_q;
  logic demand;

  assign demand = fetch_req_i && !fetch_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           in_flight_q <= 1'b0;
    else if (mem_req_o)    in_flight_q <= 1'b1;
    else if (mem_rvalid_i) in_flight_q <= 1'b0;
  end

  assert_single_burst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !in_flight_q);

  assert_demand_line_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && demand) |-> (mem_line_o == req_tag_i));

  assert_next_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !demand) |-> (mem_line_o == cur_tag_i + 1'b1));

  assert_no_pf_on_branch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !demand) |-> !cur_br_i);

  assert_ready_needs_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ready_o |-> fetch_req_i);

  assert_fill_then_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_flight_q && !mem_rvalid_i && demand) |=> !mem_req_o || !$stable(req_tag_i) || !in_flight_q);
endmodule

bind line_prefetcher lp_prefetch_chk #(.TAG_W(TAG_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_req_i   (fetch_req_i),
  .req_tag_i     (req_tag),
  .fetch_ready_o (fetch_ready_o),
  .mem_req_o     (mem_req_o),
  .mem_line_o    (mem_line_o),
  .mem_rvalid_i  (mem_rvalid_i),
  .cur_tag_i     (cur_tag),
  .cur_br_i      (cur_br)
);

// File: tb/sim_line_prefetcher.sv
`timescale 1ns/1ps
module sim_line_prefetcher;
  localparam int ADDR_W = 16;
  localparam int TAG_W  = 14;
  localparam int LAT    = 38;
  localparam int NV     = 27;

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  wait_c;
    logic [3:0]  rq;
  } vec_t;

  // processor issues each fetch two cycles after the previous delivery
  localparam vec_t VEC [NV] = '{
    '{16'd0,  8'd38, 4'd3},  // R3 cold miss
    '{16'd1,  8'd0,  4'd4},  // R4
    '{16'd2,  8'd0,  4'd4},
    '{16'd3,  8'd0,  4'd4},
    '{16'd4,  8'd30, 4'd5},  // R5 background burst started at first delivery
    '{16'd5,  8'd0,  4'd4},
    '{16'd6,  8'd0,  4'd4},
    '{16'd7,  8'd0,  4'd4},
    '{16'd8,  8'd31, 4'd7},  // R7 burst starts the cycle after the swap
    '{16'd9,  8'd0,  4'd4},
    '{16'd10, 8'd0,  4'd4},
    '{16'd11, 8'd0,  4'd4},
    '{16'd12, 8'd31, 4'd7},
    '{16'd13, 8'd0,  4'd4},
    '{16'd14, 8'd0,  4'd4},
    '{16'd15, 8'd0,  4'd4},
    '{16'd16, 8'd31, 4'd7},
    '{16'd17, 8'd0,  4'd4},
    '{16'd18, 8'd0,  4'd6},  // R6 branch word, not taken
    '{16'd19, 8'd0,  4'd4},
    '{16'd20, 8'd38, 4'd6},  // R6 no burst from branch line
    '{16'd21, 8'd0,  4'd4},
    '{16'd40, 8'd72, 4'd8},  // R8 taken branch waits for foreign burst
    '{16'd41, 8'd0,  4'd4},
    '{16'd45, 8'd34, 4'd8},  // R8 jump into line in flight
    '{16'd41, 8'd75, 4'd9},  // R9 old line invalidated by new burst
    '{16'd42, 8'd0,  4'd4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_req = 1'b0;
  logic [ADDR_W-1:0] fetch_addr = '0;
  logic fetch_ready;
  logic [31:0] fetch_instr;
  logic mem_req;
  logic [TAG_W-1:0] mem_line;
  logic mem_rvalid;
  logic [127:0] mem_rdata;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  int cnt;
  logic [TAG_W-1:0] line_q;

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  line_prefetcher u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i(fetch_req), .fetch_addr_i(fetch_addr),
    .fetch_ready_o(fetch_ready), .fetch_instr_o(fetch_instr),
    .mem_req_o(mem_req), .mem_line_o(mem_line),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  // R6 encoding: bits [31:26] == 6'b000100 marks a branch; word 18 only
  function automatic logic [31:0] mk_instr(input int a);
    logic [5:0] opc;
    opc = (a == 18) ? 6'b000100 : 6'b100000;
    return {opc, 10'd0, a[15:0]};
  endfunction

  // main memory: line returned 38 cycles after the request cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= 0;
      line_q <= '0;
    end else if (mem_req) begin
      cnt    <= LAT - 1;
      line_q <= mem_line;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
    end
  end
  assign mem_rvalid = (cnt == 1);
  always_comb begin
    for (int k = 0; k < 4; k++)
      mem_rdata[k*32 +: 32] = mk_instr(int'(line_q) * 4 + k);
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_fetch(input int a, input int exp_wait, input int rq);
    int r;
    @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = a[ADDR_W-1:0];
    r = cyc;
    #1;
    while (!fetch_ready) begin
      @(negedge clk);
      #1;
    end
    chk(cyc - r == exp_wait, $sformatf("R%0d wait addr %0d", rq, a), cyc - r, exp_wait);
    chk(fetch_instr == mk_instr(a), $sformatf("R1 data addr %0d", a),
        int'(fetch_instr), int'(mk_instr(a)));
    @(negedge clk);
    fetch_req = 1'b0;
  endtask

  task automatic run_all();
    bit seen_req;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    seen_req = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (mem_req) seen_req = 1'b1;
    end
    chk(!seen_req, "R2 idle memory request", int'(seen_req), 0);
    chk(!fetch_ready, "R2 ready after reset", int'(fetch_ready), 0);
    for (int i = 0; i < NV; i++)
      do_fetch(int'(VEC[i].addr), int'(VEC[i].wait_c), int'(VEC[i].rq));
    // R10: line 10 is resident, request low must still give no ready
    @(negedge clk);
    fetch_addr = 16'd41;
    #1;
    chk(!fetch_ready, "R10 ready without request", int'(fetch_ready), 0);
    // R4: same resident word with request gives ready at once
    fetch_req = 1'b1;
    #1;
    chk(fetch_ready, "R4 resident hit", int'(fetch_ready), 1);
    @(negedge clk);
    fetch_req = 1'b0;
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule